// File: doc/BRIEF.md
# Split-Mode Latched Performance Counter Bank

This block is a bank of four 32-bit event counters behind a single-cycle register port. Each physical counter can be switched to split mode, in which it becomes two independent 16-bit counters. The bank therefore presents up to eight logical counters. Logical counter n sits on physical counter n mod 4: in split mode, logical 0-3 are the upper halves and logical 4-7 are the lower halves.

Writes to a counter never touch the running count. They fill a per-physical holding latch and raise a pending flag. A control write with the enable bit set moves every pending latch into its live counter, and this works even when the bank is already enabled. While a value is pending, a read of that counter returns the latch.

Counter wrap-around sets sticky overflow bits in a status word. Reading the status word returns those bits and clears them. Writing the status word loads an interrupt mask. The interrupt output is high while any masked overflow bit is set.

The 32-bit register data always travels in the upper half of a 64-bit bus word, and the lower half is zero on reads. A small response state machine has two states:
- `ST_IDLE`: no read data is being presented.
- `ST_RESP`: the read result is presented for one cycle.

Transitions:
- `ST_IDLE` goes to `ST_RESP` on a read request.
- `ST_RESP` stays in `ST_RESP` on a back-to-back read.
- `ST_RESP` returns to `ST_IDLE` otherwise.

Top module: `perf_ctr_bank`

## Requirements
- R1: After reset, every counter, latch, pending flag, the control word, the overflow bits and the mask are zero. `irq` and `bus_rvalid` are low.
- R2: A read request (`bus_req`=1, `bus_we`=0) makes `bus_rvalid` high in the next cycle, with the register value in `bus_rdata[63:32]` and zero in `bus_rdata[31:0]`. A write produces no `bus_rvalid`.
- R3: A counter write only loads the holding latch and sets the pending flag. While the flag is set, reads of that counter return the latch, and the live count is unaffected.
- R4: A control write with bit 31 = 1 copies every pending latch into its live counter and clears all pending flags. This also happens when the enable bit is already 1.
- R5: A counter increments by one per cycle in which its event input is 1 and the enable bit is 1, and holds while the enable bit is 0. In 32-bit mode, physical k counts `evt_inc[k]`.
- R6: Control bit k = 1 puts physical k in split mode. The upper half counts `evt_inc[k]` and is read at logical k. The lower half counts `evt_inc[k+4]` and is read at logical k+4. Both reads are zero-extended, and there is no carry between the halves.
- R7: In split mode, a write to logical k replaces only the upper 16 bits of the latch, and a write to logical k+4 replaces only the lower 16 bits. Each keeps the other half from the current pending-or-live value.
- R8: While physical k is in 32-bit mode, logical k+4 reads as zero and writes to it are ignored.
- R9: A wrap from all-ones to zero sets a status bit. For a 32-bit counter or an upper half, this is bit k. For a lower half, this is bit k+4.
- R10: A status read returns the overflow bits in data bits [7:0] and clears them. An overflow that occurs in the same cycle as the read survives and appears on the next read.
- R11: A status write loads the interrupt mask from data bits [7:0]. `irq` is high while any overflow bit with its mask bit set is 1, and a mask of zero forces `irq` low.
- R12: Address map:
  - 0-7: logical counters.
  - 8: control, with the enable bit at bit 31 and the split bits at bits [3:0].
  - 9: status.
  
  A control read returns the enable bit and the split bits in those positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Register access request, one per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 64 | Write data; the register value is in bits [63:32] |
| bus_rdata | output | 64 | Read data; the value is in bits [63:32] |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| evt_inc | input | 8 | Event inputs; bit k feeds physical k (upper half), bit k+4 feeds the lower half |
| irq | output | 1 | Interrupt, high while a masked overflow bit is set |

## Verification
The sharpest collision is a status read landing in the same cycle as a counter wrap. In that cycle the clear and the set act on the same sticky register.

The bench provokes it as follows:
- It commits all-ones into a 32-bit counter.
- It then issues the status read in the very cycle it pulses that counter's event input.

The read must return the old, empty status, and the following status read must show the new overflow bit. A second pairing is a commit arriving while events keep counting. It is judged by the committed value showing up exactly, with no lost or extra increment.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

    // Read-response sequencer states
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } acc_state_t;

endpackage

// File: rtl/pcb_slice.sv
// One physical counter: holding latch, pending flag, live count,
// with optional split into two independent half-width counters.
module pcb_slice #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_en,
    input  logic          split,
    input  logic          wr_hi,
    input  logic          wr_lo,
    input  logic [CW-1:0] wdata,
    input  logic          commit,
    input  logic          evt_hi,
    input  logic          evt_lo,
    output logic [CW-1:0] value,
    output logic          pend,
    output logic          ovf_hi,
    output logic          ovf_lo
);

    localparam int HW = CW / 2;
    localparam logic [CW-1:0] ONE_F = CW'(1);
    localparam logic [HW-1:0] ONE_H = HW'(1);

    logic [CW-1:0] live_q, live_d;
    logic [CW-1:0] latch_q;
    logic          pend_q;
    logic [CW-1:0] cur;

    // Newest value seen by software: pending latch beats live count
    assign cur   = pend_q ? latch_q : live_q;
    assign value = cur;
    assign pend  = pend_q;

    // Live count next state and wrap detection
    always_comb begin
        live_d = live_q;
        ovf_hi = 1'b0;
        ovf_lo = 1'b0;
        if (commit && pend_q) begin
            live_d = latch_q;
        end else if (cnt_en) begin
            if (split) begin
                if (evt_hi) begin
                    live_d[CW-1:HW] = live_q[CW-1:HW] + ONE_H;
                    ovf_hi          = &live_q[CW-1:HW];
                end
                if (evt_lo) begin
                    live_d[HW-1:0] = live_q[HW-1:0] + ONE_H;
                    ovf_lo         = &live_q[HW-1:0];
                end
            end else if (evt_hi) begin
                live_d = live_q + ONE_F;
                ovf_hi = &live_q;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= '0;
        end else begin
            live_q <= live_d;
        end
    end

    // Holding latch: merged writes, cleared flag on commit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
            pend_q  <= 1'b0;
        end else if (wr_hi) begin
            latch_q <= split ? {wdata[HW-1:0], cur[HW-1:0]} : wdata;
            pend_q  <= 1'b1;
        end else if (wr_lo && split) begin
            latch_q <= {cur[CW-1:HW], wdata[HW-1:0]};
            pend_q  <= 1'b1;
        end else if (commit) begin
            pend_q  <= 1'b0;
        end
    end

endmodule

// File: rtl/pcb_regif.sv
// Write decode, control word, interrupt mask and sticky overflow bits.
module pcb_regif #(
    parameter int NPHYS = 4,
    parameter int CW    = 32,
    parameter int AW    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [AW-1:0]        bus_addr,
    input  logic [CW-1:0]        wdata,
    input  logic [2*NPHYS-1:0]   ovf_set,
    output logic [NPHYS-1:0]     wr_hi,
    output logic [NPHYS-1:0]     wr_lo,
    output logic                 commit,
    output logic                 ctrl_en,
    output logic [NPHYS-1:0]     split,
    output logic [2*NPHYS-1:0]   ovf,
    output logic                 irq
);

    localparam int NLOG = 2 * NPHYS;
    localparam logic [AW-1:0] ADDR_CTL = AW'(NLOG);
    localparam logic [AW-1:0] ADDR_STS = AW'(NLOG + 1);

    logic             is_wr, is_rd;
    logic             ctl_wr, sts_wr, sts_rd;
    logic [NLOG-1:0]  mask_q;
    logic             unused_wmid;

    assign is_wr       = bus_req && bus_we;
    assign is_rd       = bus_req && !bus_we;
    assign ctl_wr      = is_wr && (bus_addr == ADDR_CTL);
    assign sts_wr      = is_wr && (bus_addr == ADDR_STS);
    assign sts_rd      = is_rd && (bus_addr == ADDR_STS);
    assign commit      = ctl_wr && wdata[CW-1];
    assign unused_wmid = ^wdata;

    genvar k;
    generate
        for (k = 0; k < NPHYS; k++) begin : g_wdec
            assign wr_hi[k] = is_wr && (bus_addr == AW'(k));
            assign wr_lo[k] = is_wr && (bus_addr == AW'(k + NPHYS));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en <= 1'b0;
            split   <= '0;
        end else if (ctl_wr) begin
            ctrl_en <= wdata[CW-1];
            split   <= wdata[NPHYS-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (sts_wr) begin
            mask_q <= wdata[NLOG-1:0];
        end
    end

    // New wraps win over the read-clear of the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf <= '0;
        end else begin
            ovf <= (sts_rd ? '0 : ovf) | ovf_set;
        end
    end

    assign irq = |(ovf & mask_q);

endmodule

// File: rtl/pcb_rdpath.sv
// Read multiplexer with a registered one-cycle response sequencer.
module pcb_rdpath
    import pcb_pkg::*;
#(
    parameter int NPHYS = 4,
    parameter int CW    = 32,
    parameter int AW    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_req,
    input  logic [AW-1:0]        bus_addr,
    input  logic [NPHYS*CW-1:0]  val_flat,
    input  logic [NPHYS-1:0]     split,
    input  logic                 ctrl_en,
    input  logic [2*NPHYS-1:0]   ovf,
    output logic                 rvalid,
    output logic [CW-1:0]        rdata
);

    localparam int NLOG = 2 * NPHYS;
    localparam int HW   = CW / 2;
    localparam logic [AW-1:0] ADDR_CTL = AW'(NLOG);
    localparam logic [AW-1:0] ADDR_STS = AW'(NLOG + 1);

    acc_state_t    state_q, state_d;
    logic [CW-1:0] sel;
    logic [CW-1:0] rdata_q;
    logic [CW-1:0] v;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_req) state_d = ST_RESP;
            ST_RESP: state_d = rd_req ? ST_RESP : ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Register selection
    always_comb begin
        sel = '0;
        v   = '0;
        for (int k = 0; k < NPHYS; k++) begin
            v = val_flat[k*CW +: CW];
            if (bus_addr == AW'(k)) begin
                sel = split[k] ? CW'(v[CW-1:HW]) : v;
            end
            if (bus_addr == AW'(k + NPHYS)) begin
                sel = split[k] ? CW'(v[HW-1:0]) : '0;
            end
        end
        if (bus_addr == ADDR_CTL) begin
            sel            = '0;
            sel[CW-1]      = ctrl_en;
            sel[NPHYS-1:0] = split;
        end
        if (bus_addr == ADDR_STS) begin
            sel           = '0;
            sel[NLOG-1:0] = ovf;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_req) begin
            rdata_q <= sel;
        end
    end

    // Outputs
    always_comb begin
        rvalid = (state_q == ST_RESP);
        rdata  = rvalid ? rdata_q : '0;
    end

endmodule

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank #(
    parameter int NPHYS = 4,
    parameter int AW    = 4,
    parameter int BUS_W = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [AW-1:0]        bus_addr,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    output logic                 bus_rvalid,
    input  logic [2*NPHYS-1:0]   evt_inc,
    output logic                 irq
);

    localparam int CW   = BUS_W / 2;
    localparam int NLOG = 2 * NPHYS;

    logic [CW-1:0]       wdata32;
    logic                unused_wlo;
    logic [NPHYS-1:0]    wr_hi, wr_lo, split, pend_vec;
    logic                commit, ctrl_en;
    logic [NLOG-1:0]     sts_ovf, ovf_set;
    logic [NPHYS*CW-1:0] val_flat;
    logic [CW-1:0]       rdata32;

    assign wdata32    = bus_wdata[BUS_W-1 -: CW];
    assign unused_wlo = ^bus_wdata[CW-1:0];

    pcb_regif #(.NPHYS(NPHYS), .CW(CW), .AW(AW)) u_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_req  (bus_req),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .wdata    (wdata32),
        .ovf_set  (ovf_set),
        .wr_hi    (wr_hi),
        .wr_lo    (wr_lo),
        .commit   (commit),
        .ctrl_en  (ctrl_en),
        .split    (split),
        .ovf      (sts_ovf),
        .irq      (irq)
    );

    genvar k;
    generate
        for (k = 0; k < NPHYS; k++) begin : g_ctr
            pcb_slice #(.CW(CW)) u_slice (
                .clk    (clk),
                .rst_n  (rst_n),
                .cnt_en (ctrl_en),
                .split  (split[k]),
                .wr_hi  (wr_hi[k]),
                .wr_lo  (wr_lo[k]),
                .wdata  (wdata32),
                .commit (commit),
                .evt_hi (evt_inc[k]),
                .evt_lo (evt_inc[k+NPHYS]),
                .value  (val_flat[k*CW +: CW]),
                .pend   (pend_vec[k]),
                .ovf_hi (ovf_set[k]),
                .ovf_lo (ovf_set[k+NPHYS])
            );
        end
    endgenerate

    pcb_rdpath #(.NPHYS(NPHYS), .CW(CW), .AW(AW)) u_rdpath (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (bus_req && !bus_we),
        .bus_addr (bus_addr),
        .val_flat (val_flat),
        .split    (split),
        .ctrl_en  (ctrl_en),
        .ovf      (sts_ovf),
        .rvalid   (bus_rvalid),
        .rdata    (rdata32)
    );

    assign bus_rdata = {rdata32, {CW{1'b0}}};

endmodule

// File: rtl/pcb_checker.sv
module pcb_checker #(
    parameter int NPHYS = 4,
    parameter int AW    = 4,
    parameter int BUS_W = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_req,
    input logic                bus_we,
    input logic [AW-1:0]       bus_addr,
    input logic [BUS_W-1:0]    bus_wdata,
    input logic                bus_rvalid,
    input logic                irq,
    input logic                ctrl_en,
    input logic [NPHYS-1:0]    pend_vec,
    input logic [2*NPHYS-1:0]  sts_ovf
);

    localparam int NLOG = 2 * NPHYS;
    localparam int CW   = BUS_W / 2;

    logic ctl_wr, sts_wr, sts_rd, ctr_wr_hi;
    logic [NLOG-1:0] wmask;
    logic unused_chk;

    assign ctl_wr    = bus_req && bus_we && (bus_addr == AW'(NLOG));
    assign sts_wr    = bus_req && bus_we && (bus_addr == AW'(NLOG + 1));
    assign sts_rd    = bus_req && !bus_we && (bus_addr == AW'(NLOG + 1));
    assign ctr_wr_hi = bus_req && bus_we && (bus_addr < AW'(NPHYS));
    assign wmask     = bus_wdata[CW +: NLOG];
    assign unused_chk = ^bus_wdata;

    AST_RD_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid); // R2
    AST_WR_NO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we) |=> !bus_rvalid); // R2
    AST_PEND_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_wr_hi |=> (pend_vec != '0)); // R3
    AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && bus_wdata[BUS_W-1]) |=> (pend_vec == '0)); // R4
    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable(ctrl_en)); // R4
    AST_NO_OVF_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && sts_rd) |=> (sts_ovf == '0)); // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_rd |=> ((sts_ovf & $past(sts_ovf)) == $past(sts_ovf))); // R10
    AST_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr && (wmask == '0)) |=> !irq); // R11

endmodule

bind perf_ctr_bank pcb_checker #(.NPHYS(NPHYS), .AW(AW), .BUS_W(BUS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rvalid (bus_rvalid),
    .irq        (irq),
    .ctrl_en    (ctrl_en),
    .pend_vec   (pend_vec),
    .sts_ovf    (sts_ovf)
);

// File: tb/sim_perf_ctr_bank.sv
`timescale 1ns/1ps
module sim_perf_ctr_bank;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_EV = 2'd2;
    localparam logic [3:0] A_CTL = 4'd8;
    localparam logic [3:0] A_STS = 4'd9;
    localparam int NV = 32;

    // {op, addr (cycles for OP_EV), data (event mask for OP_EV), expected}
    localparam logic [69:0] VEC [NV] = '{
        {OP_WR, 4'd0,  32'h0000_0010, 32'h0},           // R3 write to latch
        {OP_RD, 4'd0,  32'h0,         32'h0000_0010},   // R3 latch visible
        {OP_EV, 4'd5,  32'h01,        32'h0},           // R5 disabled events
        {OP_RD, 4'd0,  32'h0,         32'h0000_0010},   // R3
        {OP_WR, A_CTL, 32'h8000_0000, 32'h0},           // R4 enable commits
        {OP_RD, 4'd0,  32'h0,         32'h0000_0010},   // R4
        {OP_EV, 4'd3,  32'h01,        32'h0},
        {OP_RD, 4'd0,  32'h0,         32'h0000_0013},   // R5 counting
        {OP_WR, 4'd0,  32'h0000_0100, 32'h0},           // R3 write while enabled
        {OP_EV, 4'd2,  32'h01,        32'h0},
        {OP_RD, 4'd0,  32'h0,         32'h0000_0100},   // R3 pending wins
        {OP_WR, A_CTL, 32'h8000_0000, 32'h0},           // R4 rewrite commits
        {OP_RD, 4'd0,  32'h0,         32'h0000_0100},   // R4
        {OP_RD, A_CTL, 32'h0,         32'h8000_0000},   // R12
        {OP_WR, A_CTL, 32'h8000_0002, 32'h0},           // R6 split phys 1
        {OP_WR, 4'd1,  32'h0000_ABCD, 32'h0},           // R7 upper half
        {OP_WR, 4'd5,  32'h0000_1234, 32'h0},           // R7 lower half
        {OP_RD, 4'd1,  32'h0,         32'h0000_ABCD},   // R7
        {OP_RD, 4'd5,  32'h0,         32'h0000_1234},   // R7
        {OP_WR, A_CTL, 32'h8000_0002, 32'h0},           // R4
        {OP_EV, 4'd4,  32'h22,        32'h0},
        {OP_RD, 4'd1,  32'h0,         32'h0000_ABD1},   // R6
        {OP_RD, 4'd5,  32'h0,         32'h0000_1238},   // R6
        {OP_EV, 4'd2,  32'h20,        32'h0},
        {OP_RD, 4'd1,  32'h0,         32'h0000_ABD1},   // R6 halves independent
        {OP_RD, 4'd5,  32'h0,         32'h0000_123A},   // R6
        {OP_RD, 4'd6,  32'h0,         32'h0},           // R8
        {OP_WR, 4'd6,  32'h0000_5555, 32'h0},           // R8 ignored write
        {OP_RD, 4'd2,  32'h0,         32'h0},           // R8
        {OP_RD, 4'd6,  32'h0,         32'h0},           // R8
        {OP_RD, A_CTL, 32'h0,         32'h8000_0002},   // R12
        {OP_RD, A_STS, 32'h0,         32'h0}            // R10 nothing pending
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic        bus_rvalid;
    logic [7:0]  evt_inc = '0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    perf_ctr_bank u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .evt_inc    (evt_inc),
        .irq        (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One bus cycle; returns at the following falling edge
    task automatic access(input logic we, input logic [3:0] a, input logic [31:0] d,
                          input logic [7:0] ev);
        bus_req   = 1'b1;
        bus_we    = we;
        bus_addr  = a;
        bus_wdata = {d, 32'h0};
        evt_inc   = ev;
        @(negedge clk);
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        evt_inc   = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
        access(1'b0, a, 32'h0, 8'h0);
        chk({tag, " rvalid"}, 32'(bus_rvalid), 32'h1);
        chk({tag, " low half"}, bus_rdata[31:0], 32'h0);
        chk(tag, bus_rdata[63:32], exp);
    endtask

    task automatic pulse(input logic [7:0] m, input int n);
        for (int c = 0; c < n; c++) begin
            evt_inc = m;
            @(negedge clk);
        end
        evt_inc = '0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 irq in reset", 32'(irq), 32'h0);
        chk("R1 rvalid in reset", 32'(bus_rvalid), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 10; a++) rd_chk("R1 reg after reset", 4'(a), 32'h0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            case (VEC[i][69:68])
                OP_WR: begin
                    access(1'b1, VEC[i][67:64], VEC[i][63:32], 8'h0);
                    checks++;
                    if (bus_rvalid !== 1'b0) begin
                        fails++;
                        $display("FAIL R2 table[%0d] write rvalid: actual %b expected 0", i, bus_rvalid);
                    end
                end
                OP_RD: begin
                    access(1'b0, VEC[i][67:64], 32'h0, 8'h0);
                    checks++;
                    if (bus_rvalid !== 1'b1 || bus_rdata !== {VEC[i][31:0], 32'h0}) begin
                        fails++;
                        $display("FAIL table[%0d] addr %0d: actual %h expected %h", i,
                                 VEC[i][67:64], bus_rdata, {VEC[i][31:0], 32'h0});
                    end
                end
                default: pulse(VEC[i][39:32], int'(VEC[i][67:64]));
            endcase
        end

        // R9 / R11: 32-bit wrap on physical 3
        access(1'b1, 4'd3, 32'hFFFF_FFFE, 8'h0);
        access(1'b1, A_CTL, 32'h8000_0002, 8'h0);
        access(1'b1, A_STS, 32'h0000_0008, 8'h0);
        pulse(8'h08, 1);
        chk("R9 no wrap at all-ones", 32'(irq), 32'h0);
        pulse(8'h08, 1);
        chk("R11 irq on masked wrap", 32'(irq), 32'h1);
        rd_chk("R9 wrapped count", 4'd3, 32'h0);
        rd_chk("R10 status bit 3", A_STS, 32'h0000_0008);
        chk("R10 irq after clear", 32'(irq), 32'h0);
        rd_chk("R10 status cleared", A_STS, 32'h0);

        // R9 / R11: lower-half wrap on split physical 1
        access(1'b1, 4'd5, 32'h0000_FFFF, 8'h0);
        access(1'b1, A_CTL, 32'h8000_0002, 8'h0);
        access(1'b1, A_STS, 32'h0000_0020, 8'h0);
        pulse(8'h20, 1);
        chk("R11 irq lower-half wrap", 32'(irq), 32'h1);
        rd_chk("R9 lower half wrapped", 4'd5, 32'h0);
        rd_chk("R6 upper half no carry", 4'd1, 32'h0000_ABD1);
        access(1'b1, A_STS, 32'h0, 8'h0);
        chk("R11 zero mask drops irq", 32'(irq), 32'h0);
        rd_chk("R10 status bit 5 under zero mask", A_STS, 32'h0000_0020);

        // R10: wrap in the same cycle as the status read
        access(1'b1, 4'd0, 32'hFFFF_FFFF, 8'h0);
        access(1'b1, A_CTL, 32'h8000_0002, 8'h0);
        access(1'b0, A_STS, 32'h0, 8'h01);
        chk("R10 coincident read old value", bus_rdata[63:32], 32'h0);
        rd_chk("R10 coincident wrap kept", A_STS, 32'h0000_0001);

        // R5 disabled holds, R12 control readback
        access(1'b1, A_CTL, 32'h0000_0002, 8'h0);
        pulse(8'h02, 3);
        rd_chk("R5 disabled holds", 4'd1, 32'h0000_ABD1);
        rd_chk("R12 control readback", A_CTL, 32'h0000_0002);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule